// File: doc/BRIEF.md
# Two-wire register control port

This block is a slave-only control port for a two-wire serial bus of the I2C kind. It has a bidirectional data line and a clock that the bus master drives. The block samples both lines with its own system clock. It recognises start and stop conditions and matches a 7-bit device address. The address has six fixed upper bits and a lowest bit taken from a strap input. After a write address, the first byte loads an internal register pointer. Every later byte is stored in the register that the pointer selects. After a read address, the block shifts out the selected register, MSB first, for as long as the master acknowledges.

The pointer byte carries an auto-advance flag. When the flag is set, the pointer moves to the next register after each byte written or read, and it wraps past the last register. The pointer keeps its value across transactions. A master can therefore write only a pointer, then start a read (after a repeated start or a stop) and receive the register it selected. The data line is driven open-drain: the block only ever asserts an enable that pulls the line low. The whole register bank is also presented as a flat output, so that neighbouring logic can use the settings.

Top module: `i2c_reg_port`

## Requirements
- R1: After reset the pull-down enable is 0, every register reads 0, and the pointer is register 0 with auto-advance off.
- R2: A first byte after a start whose upper seven bits equal 0010000 with the strap level in the lowest address position (address 001000 followed by the strap bit) is acknowledged by pulling SDA low during the ninth clock. Bit 0 of that byte selects the direction: 1 means read, 0 means write.
- R3: When the address does not match, the port gives no acknowledge, changes no register and ignores every further bit until the next start.
- R4: In a write, the byte after the address loads the pointer and is acknowledged. Bit 7 is the auto-advance flag, bits [IDX_W-1:0] are the register index, and all other bits are ignored.
- R5: Each further byte in a write is stored in the register the pointer selects and is acknowledged. Registers change only on an SCL falling edge.
- R6: With auto-advance set, the pointer advances by one after each byte written or read and wraps from the last register to register 0. With auto-advance clear, it stays put. The pointer changes only on an SCL falling edge.
- R7: In a read, the port sends the selected register MSB first, changing SDA only while SCL is low.
- R8: A read continues with the next byte while the master acknowledges. A non-acknowledge ends it, and the port then leaves SDA released.
- R9: The pointer keeps its value between transactions: a read after a pointer-only write returns the selected register, and a later read carries on from where the previous one stopped.
- R10: The pull-down enable never changes while SCL stays high.
- R11: A stop (SDA rising while SCL is high) releases SDA and returns the port to idle, where clocked bytes get no acknowledge.
- R12: A start (SDA falling while SCL is high), including a repeated start inside a transaction, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample both bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| addr_sel_i | input | 1 | Strap level that supplies the lowest device-address bit |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |
| regs_o | output | REG_COUNT*8 | All registers, register k in bits [8k+7:8k] |

## Verification
The bench builds the port with its defaults: eight registers, a three-bit index and two synchronizer stages. With eight registers, a short block write from index 6 reaches the wrap from register 7 back to register 0, and a three-byte read crosses several registers. The bus clock half-period is eight system clocks. That is long enough for the synchronizer latency to fit inside each SCL low phase, so acknowledge and read-data timing are exercised at a realistic margin. Both strap levels are used, so matching and mismatching on the lowest address bit and on the fixed upper bits each occur in the vector table.

// File: rtl/i2c_port_pkg.sv
// Shared types for the two-wire register control port.
// Assumes a byte-wide register bank and oversampling of the bus by clk.
package i2c_port_pkg;

    localparam int BYTE_W = 8;

    // Protocol engine states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } port_state_e;

    // Which byte of a write-direction transfer is being received
    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA
    } rx_phase_e;

    // Synchronised line levels and decoded bus events
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

endpackage

// File: rtl/i2c_line_monitor.sv
// Synchronises SCL and SDA into clk and decodes edges, start and stop.
// Assumes both lines idle high and are slow compared with clk.
module i2c_line_monitor
    import i2c_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    logic scl_s, sda_s;
    logic scl_p, sda_p;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            logic scl_ff, sda_ff;
            // single-stage capture of both lines
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ff <= 1'b1;
                    sda_ff <= 1'b1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
            assign scl_s = scl_ff;
            assign sda_s = sda_ff;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
            // multi-stage synchroniser chain for both lines
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
                end
            end
            assign scl_s = scl_ff[SYNC_STAGES-1];
            assign sda_s = sda_ff[SYNC_STAGES-1];
        end
    endgenerate

    // previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // event decode: SDA edges count as start or stop only with SCL held high
    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/i2c_reg_bank.sv
// Byte-wide register bank with one write port and one read port.
// Assumes REG_COUNT is a power of two so that the index covers it exactly.
module i2c_reg_bank
    import i2c_port_pkg::*;
#(
    parameter int REG_COUNT = 8,
    parameter int IDX_W     = $clog2(REG_COUNT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [BYTE_W-1:0]           wr_data,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [BYTE_W-1:0]           rd_data,
    output logic [REG_COUNT*BYTE_W-1:0] regs_flat
);

    logic [BYTE_W-1:0] mem [REG_COUNT];

    // storage update: clear on reset, else write the addressed entry
    always_ff @(posedge clk) begin
        for (int i = 0; i < REG_COUNT; i++) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (wr_en && (wr_idx == i[IDX_W-1:0])) begin
                mem[i] <= wr_data;
            end
        end
    end

    // read port selected by the shared pointer
    assign rd_data = mem[rd_idx];

    genvar g;
    generate
        for (g = 0; g < REG_COUNT; g++) begin : g_flat
            assign regs_flat[g*BYTE_W +: BYTE_W] = mem[g];
        end
    endgenerate

endmodule

// File: rtl/i2c_port_ctrl.sv
// Protocol engine: address match, pointer load, byte write, byte read,
// acknowledge handling and the open-drain pull-down enable.
// Assumes decoded bus events from i2c_line_monitor; SDA is changed only on
// the cycle an SCL fall is seen, so it always moves while SCL is low.
module i2c_port_ctrl
    import i2c_port_pkg::*;
#(
    parameter int          IDX_W  = 3,
    parameter logic [5:0]  DEV_HI = 6'b001000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_ev_t          ev,
    input  logic              addr_sel,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic [IDX_W-1:0]  ptr_idx,
    output logic              sda_oe,
    output logic              busy
);

    port_state_e       state;
    rx_phase_e         phase;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic              is_read;
    logic              ptr_inc;
    logic              mack;
    logic [IDX_W-1:0]  ptr_next;
    logic              byte_in;

    // pointer successor, wrapping through the power-of-two index space
    assign ptr_next = ptr_idx + {{(IDX_W-1){1'b0}}, ptr_inc};
    // a full byte has been shifted in and its eighth clock has ended
    assign byte_in  = (state == ST_RX) && ev.scl_fall && (cnt == 4'd8);

    // register write strobe for data bytes of a write transfer
    always_comb begin
        wr_en   = byte_in && (phase == PH_DATA);
        wr_data = shreg;
    end

    assign busy = (state != ST_IDLE);

    // protocol sequencing, pointer maintenance and SDA pull-down control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= PH_ADDR;
            cnt     <= '0;
            shreg   <= '0;
            txreg   <= '0;
            is_read <= 1'b0;
            ptr_inc <= 1'b0;
            ptr_idx <= '0;
            mack    <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (ev.start) begin
            state   <= ST_RX;
            phase   <= PH_ADDR;
            cnt     <= '0;
            is_read <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (ev.scl_rise && (cnt != 4'd8)) begin
                        shreg <= {shreg[BYTE_W-2:0], ev.sda};
                        cnt   <= cnt + 4'd1;
                    end
                    if (byte_in) begin
                        cnt <= '0;
                        case (phase)
                            PH_ADDR: begin
                                if (shreg[7:1] == {DEV_HI, addr_sel}) begin
                                    is_read <= shreg[0];
                                    sda_oe  <= 1'b1;
                                    state   <= ST_RX_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            PH_PTR: begin
                                ptr_inc <= shreg[7];
                                ptr_idx <= shreg[IDX_W-1:0];
                                sda_oe  <= 1'b1;
                                state   <= ST_RX_ACK;
                            end
                            default: begin
                                ptr_idx <= ptr_next;
                                sda_oe  <= 1'b1;
                                state   <= ST_RX_ACK;
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (ev.scl_fall) begin
                        if (is_read) begin
                            txreg   <= rd_data;
                            sda_oe  <= ~rd_data[7];
                            ptr_idx <= ptr_next;
                            cnt     <= '0;
                            state   <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            phase  <= (phase == PH_ADDR) ? PH_PTR : PH_DATA;
                            state  <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (cnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TX_ACK;
                        end else begin
                            txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~txreg[6];
                            cnt    <= cnt + 4'd1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev.scl_rise) begin
                        mack <= ~ev.sda;
                    end
                    if (ev.scl_fall) begin
                        if (mack) begin
                            txreg   <= rd_data;
                            sda_oe  <= ~rd_data[7];
                            ptr_idx <= ptr_next;
                            cnt     <= '0;
                            state   <= ST_TX;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_reg_port.sv
// Top of the two-wire register control port: line monitor, protocol engine
// and register bank. Assumes REG_COUNT is a power of two between 2 and 128.
module i2c_reg_port
    import i2c_port_pkg::*;
#(
    parameter int         REG_COUNT   = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] DEV_HI      = 6'b001000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scl_i,
    input  logic                        sda_i,
    input  logic                        addr_sel_i,
    output logic                        sda_oe_o,
    output logic [REG_COUNT*BYTE_W-1:0] regs_o
);

    localparam int IDX_W = $clog2(REG_COUNT);

    line_ev_t          line_ev;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic [IDX_W-1:0]  ptr_idx;
    logic [BYTE_W-1:0] rd_data;
    logic              port_busy;

    i2c_line_monitor #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (line_ev)
    );

    i2c_port_ctrl #(
        .IDX_W  (IDX_W),
        .DEV_HI (DEV_HI)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (line_ev),
        .addr_sel (addr_sel_i),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ptr_idx  (ptr_idx),
        .sda_oe   (sda_oe_o),
        .busy     (port_busy)
    );

    i2c_reg_bank #(
        .REG_COUNT (REG_COUNT),
        .IDX_W     (IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (ptr_idx),
        .wr_data   (wr_data),
        .rd_idx    (ptr_idx),
        .rd_data   (rd_data),
        .regs_flat (regs_o)
    );

endmodule

// File: rtl/i2c_reg_port_chk.sv
// Property checker for i2c_reg_port, attached with bind below.
// Assumes it observes the top ports and the decoded line events.
module i2c_reg_port_chk
    import i2c_port_pkg::*;
#(
    parameter int REG_COUNT = 8,
    parameter int IDX_W     = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        scl_i,
    input logic                        sda_oe,
    input line_ev_t                    ev,
    input logic                        busy,
    input logic [IDX_W-1:0]            ptr_idx,
    input logic [REG_COUNT*BYTE_W-1:0] regs
);

    // R10: the pull-down enable holds while the raw clock line stays high
    assert_sda_quiet_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe));

    // R6: the pointer moves only on an SCL falling edge
    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ev.scl_fall |=> $stable(ptr_idx));

    // R5: registers change only on an SCL falling edge
    assert_regs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ev.scl_fall |=> $stable(regs));

    // R12: a start always leaves the port receiving an address
    assert_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ev.start |=> busy);

    // R11: a stop releases the data line and idles the port
    assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev.stop |=> (!sda_oe && !busy));

endmodule

bind i2c_reg_port i2c_reg_port_chk #(
    .REG_COUNT (REG_COUNT),
    .IDX_W     (IDX_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_oe  (sda_oe_o),
    .ev      (line_ev),
    .busy    (port_busy),
    .ptr_idx (ptr_idx),
    .regs    (regs_o)
);

// File: tb/test_i2c_reg_port.sv
module test_i2c_reg_port;

    localparam int HP = 8;

    typedef struct packed {
        logic       asel;
        logic [6:0] dev;
        logic [7:0] ptr;
        logic [7:0] data;
        logic       ack;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{asel: 1'b0, dev: 7'h10, ptr: 8'h02, data: 8'hA5, ack: 1'b1},
        '{asel: 1'b1, dev: 7'h11, ptr: 8'h05, data: 8'h3C, ack: 1'b1},
        '{asel: 1'b1, dev: 7'h10, ptr: 8'h03, data: 8'hFF, ack: 1'b0},
        '{asel: 1'b0, dev: 7'h11, ptr: 8'h04, data: 8'h77, ack: 1'b0},
        '{asel: 1'b0, dev: 7'h30, ptr: 8'h01, data: 8'h12, ack: 1'b0},
        '{asel: 1'b0, dev: 7'h10, ptr: 8'h87, data: 8'h81, ack: 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        master_sda = 1'b1;
    logic        addr_sel = 1'b0;
    logic        sda_oe;
    logic [63:0] regs;
    logic        sda_line;
    logic [63:0] model = '0;
    int          checks = 0;
    int          errors = 0;
    int          r10_viol = 0;
    bit          done = 1'b0;
    logic        prev_scl = 1'b1;
    logic        prev_oe = 1'b0;

    assign sda_line = master_sda & ~sda_oe;

    always #10 clk = ~clk;

    i2c_reg_port i_i2c_reg_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .addr_sel_i (addr_sel),
        .sda_oe_o   (sda_oe),
        .regs_o     (regs)
    );

    // R10 monitor: enable must not move while SCL stays high
    always @(negedge clk) begin
        if (rst_n && scl && prev_scl && (sda_oe != prev_oe)) r10_viol++;
        prev_scl <= scl;
        prev_oe  <= sda_oe;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        master_sda = 1'b1; wait_clk(HP);
        scl = 1'b1;        wait_clk(HP);
        master_sda = 1'b0; wait_clk(HP);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clk(2); master_sda = 1'b0; wait_clk(HP - 2);
        scl = 1'b1;        wait_clk(HP);
        master_sda = 1'b1; wait_clk(HP);
    endtask

    task automatic send_bit(input logic b);
        wait_clk(2); master_sda = b; wait_clk(HP - 2);
        scl = 1'b1; wait_clk(HP);
        scl = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        wait_clk(2); master_sda = 1'b1; wait_clk(HP - 2);
        scl = 1'b1; wait_clk(HP / 2);
        ack = ~sda_line;
        wait_clk(HP / 2);
        scl = 1'b0;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        wait_clk(2); master_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_clk(HP);
            scl = 1'b1; wait_clk(HP / 2);
            b[i] = sda_line;
            wait_clk(HP / 2);
            scl = 1'b0;
        end
        send_bit(~give_ack);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            finish_run();
        end
    end

    initial begin
        logic       ack;
        logic [7:0] rb;

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);

        // R1: reset state at the ports
        check(sda_oe == 1'b0, "R1 reset pull-down", {63'd0, sda_oe}, 64'd0);
        check(regs == 64'd0, "R1 reset registers", regs, 64'd0);

        // R1: pointer resets to register 0, read returns it
        addr_sel = 1'b0;
        bus_start();
        write_byte({7'h10, 1'b1}, ack);
        check(ack, "R2 read address ack", {63'd0, ack}, 64'd1);
        read_byte(1'b0, rb);
        check(rb == 8'h00, "R1 read after reset", {56'd0, rb}, 64'd0);
        bus_stop();

        // R2 R3 R4 R5: vector table of write transfers
        for (int v = 0; v < NVEC; v++) begin
            addr_sel = VECS[v].asel;
            bus_start();
            write_byte({VECS[v].dev, 1'b0}, ack);
            check(ack == VECS[v].ack, VECS[v].ack ? "R2 address ack" : "R3 address no ack",
                  {63'd0, ack}, {63'd0, VECS[v].ack});
            write_byte(VECS[v].ptr, ack);
            check(ack == VECS[v].ack, "R4 pointer byte ack", {63'd0, ack}, {63'd0, VECS[v].ack});
            write_byte(VECS[v].data, ack);
            check(ack == VECS[v].ack, "R5 data byte ack", {63'd0, ack}, {63'd0, VECS[v].ack});
            bus_stop();
            if (VECS[v].ack) model[VECS[v].ptr[2:0]*8 +: 8] = VECS[v].data;
            check(regs == model, VECS[v].ack ? "R5 register write" : "R3 registers untouched",
                  regs, model);
        end

        // R6: auto-advance block write wrapping from 7 to 0
        addr_sel = 1'b1;
        bus_start();
        write_byte({7'h11, 1'b0}, ack);
        write_byte(8'h86, ack);
        write_byte(8'h11, ack);
        write_byte(8'h22, ack);
        write_byte(8'h33, ack);
        write_byte(8'h66, ack);
        check(ack, "R5 last block byte ack", {63'd0, ack}, 64'd1);
        bus_stop();
        model[6*8 +: 8] = 8'h11;
        model[7*8 +: 8] = 8'h22;
        model[0*8 +: 8] = 8'h33;
        model[1*8 +: 8] = 8'h66;
        check(regs == model, "R6 advance and wrap", regs, model);

        // R6: auto-advance clear keeps the pointer fixed
        bus_start();
        write_byte({7'h11, 1'b0}, ack);
        write_byte(8'h03, ack);
        write_byte(8'h44, ack);
        write_byte(8'h55, ack);
        bus_stop();
        model[3*8 +: 8] = 8'h55;
        check(regs == model, "R6 pointer held", regs, model);

        // R9 R12: pointer-only write then repeated start and block read
        bus_start();
        write_byte({7'h11, 1'b0}, ack);
        write_byte(8'h81, ack);
        bus_start();
        write_byte({7'h11, 1'b1}, ack);
        check(ack, "R12 repeated start address ack", {63'd0, ack}, 64'd1);
        read_byte(1'b1, rb);
        check(rb == 8'h66, "R9 read selected register", {56'd0, rb}, 64'h66);
        read_byte(1'b1, rb);
        check(rb == 8'hA5, "R7 read next register", {56'd0, rb}, 64'hA5);
        read_byte(1'b0, rb);
        check(rb == 8'h55, "R7 read third register", {56'd0, rb}, 64'h55);
        // R8: after the non-acknowledge the line stays released
        read_byte(1'b0, rb);
        check(rb == 8'hFF, "R8 released after nack", {56'd0, rb}, 64'hFF);
        bus_stop();

        // R9: a later read carries on from the retained pointer
        bus_start();
        write_byte({7'h11, 1'b1}, ack);
        read_byte(1'b1, rb);
        check(rb == 8'h00, "R9 retained pointer reg4", {56'd0, rb}, 64'h00);
        read_byte(1'b0, rb);
        check(rb == 8'h3C, "R9 retained pointer reg5", {56'd0, rb}, 64'h3C);
        bus_stop();

        // R11: after a stop, clocked bytes are not acknowledged
        wait_clk(2); master_sda = 1'b1; wait_clk(2);
        scl = 1'b0;
        write_byte({7'h11, 1'b0}, ack);
        check(!ack, "R11 idle ignores address", {63'd0, ack}, 64'd0);
        write_byte(8'h00, ack);
        write_byte(8'hEE, ack);
        check(!ack, "R11 idle ignores data", {63'd0, ack}, 64'd0);
        scl = 1'b1; wait_clk(HP);
        check(regs == model, "R11 idle registers untouched", regs, model);

        // R10: no enable change observed while SCL high
        check(r10_viol == 0, "R10 SDA moved with SCL high", r10_viol, 64'd0);

        done = 1'b1;
        finish_run();
    end

endmodule